// File: doc/BRIEF.md
# Multichannel Auxiliary ADC Conversion Sequencer

This block sits between a simple 32-bit register bus and a single shared analog-to-digital converter with sixteen multiplexed inputs. Software asks for a sample on an input by raising that input's bit in a trigger register. It can watch a global busy flag. It then reads the input's own result word, which carries the 12-bit sample and a sticky ready flag. Several requests may be outstanding at once. The sequencer keeps them in a pending set and hands them to the converter one at a time, lowest input number first.

The converter is represented by a behavioural model inside the block. The model takes a fixed number of clock cycles and returns a known sample for each input, so every result can be predicted. The select and start signals that go to the model are brought out as ports so the order of service can be observed. A power enable bit gates all conversion activity. Requests that arrive while power is off are kept and served once power is enabled.

Top module: `adc_seq_ctrl`

## Requirements
- R1: A 0-to-1 change of bit n in the trigger register (byte offset 0x04) requests exactly one conversion of input n. Writing the bit as 1 again while it is already 1 requests nothing.
- R2: When several requests are pending, they are served one at a time in ascending input order. Each service shows a single-cycle `conv_start` with the input number on `conv_ch`.
- R3: The result word of input n is at byte offset 0x14 + 4*n. Bits 11:0 hold the last sample and bit 12 is the ready flag. The model's sample for input n is (257*n + 0x5A) mod 4096. The ready flag first reads 1 exactly LATENCY+1 clock edges after the edge that accepted the triggering write, and never earlier.
- R4: Changing trigger bit n from 1 to 0 clears the ready flag of input n and keeps its sample. If this clear and the completion of input n's conversion take effect at the same edge, the clear wins: the new sample is stored and the ready flag reads 0.
- R5: Bit 0 of the status register (offset 0x10) reads 1 while any request is pending or a conversion is in flight. It reads 0 at the latest by the edge where the last requested ready flag sets.
- R6: Bit 14 of the power register (offset 0x94) is 0 after reset. While it is 0, no conversion starts, and requests stay pending with busy at 1. Setting it lets the pending requests proceed.
- R7: Reset clears triggers, pending requests, samples, ready flags and power. Undefined offsets and offsets that are not word-aligned read 0. Writes to the result words have no effect.
- R8: The converter model accepts a start only while it is idle, and it raises `done` for exactly one cycle per start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| conv_start | output | 1 | Single-cycle start pulse to the converter |
| conv_ch | output | 4 | Input number selected for the conversion being started |

## Verification
Two things can take effect at the same clock edge: the converter finishing input n, and a software write that drops trigger bit n. The bench provokes this by raising a trigger and then timing a clearing write so that it is accepted exactly LATENCY+1 edges later, which is the edge where the result lands. The outcome is then judged at the ports. The result word must show the freshly stored sample with the ready flag at 0, and busy must already be 0. An ordinary completion of the same input would instead show the ready flag at 1.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
    // register byte offsets (software-visible, behaviour depends on them)
    localparam int OFF_TRIG  = 'h04;
    localparam int OFF_STAT  = 'h10;
    localparam int OFF_DATA0 = 'h14;
    localparam int OFF_MISC  = 'h94;
    localparam int PWR_BIT   = 14;
    // deterministic converter model: sample = ch*MUL + OFS (truncated)
    localparam int SAMPLE_MUL = 257;
    localparam int SAMPLE_OFS = 'h5A;
endpackage

// File: rtl/adc_seq_pick.sv
module adc_seq_pick #(
    parameter int N    = 16,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     req,
    output logic [N-1:0]     grant,
    output logic [IDX_W-1:0] idx,
    output logic             vld
);
    // lowest set bit wins
    assign grant = req & (~req + N'(1));
    assign vld   = |req;

    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/adc_seq_conv.sv
module adc_seq_conv import adc_seq_pkg::*; #(
    parameter int NUM_CH  = 16,
    parameter int DATA_W  = 12,
    parameter int LATENCY = 8,
    parameter int CH_W    = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CH_W-1:0]   ch,
    output logic              done,
    output logic [DATA_W-1:0] sample
);
    localparam int CNT_W = $clog2(LATENCY + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CH_W-1:0]  ch;
    } conv_t;

    conv_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (start) begin
            st_d.cnt = CNT_W'(LATENCY);
            st_d.ch  = ch;
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign done   = (st_q.cnt == CNT_W'(1));
    assign sample = DATA_W'(32'(st_q.ch) * 32'(SAMPLE_MUL) + 32'(SAMPLE_OFS));

    AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (st_q.cnt == '0));                                   // R8
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                               // R8
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl import adc_seq_pkg::*; #(
    parameter int NUM_CH  = 16,
    parameter int DATA_W  = 12,
    parameter int ADDR_W  = 8,
    parameter int LATENCY = 8,
    parameter int CH_W    = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              conv_start,
    output logic [CH_W-1:0]   conv_ch
);
    localparam int DATA_SPAN = 4 * NUM_CH;

    typedef struct packed {
        logic [NUM_CH-1:0]             trig;
        logic [NUM_CH-1:0]             pend;
        logic [NUM_CH-1:0]             rdy;
        logic [NUM_CH-1:0][DATA_W-1:0] data;
        logic                          pwr;
        logic                          active;
        logic [CH_W-1:0]               cur;
    } ctl_t;

    ctl_t q, d;

    logic [NUM_CH-1:0] grant;
    logic              grant_vld;
    logic              conv_done;
    logic [DATA_W-1:0] conv_sample;
    logic              busy;
    logic              unused_wdata;

    assign unused_wdata = ^bus_wdata;

    adc_seq_pick #(.N(NUM_CH), .IDX_W(CH_W)) u_pick (
        .req   (q.pend),
        .grant (grant),
        .idx   (conv_ch),
        .vld   (grant_vld)
    );

    adc_seq_conv #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .LATENCY(LATENCY), .CH_W(CH_W)) u_conv (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (conv_start),
        .ch     (conv_ch),
        .done   (conv_done),
        .sample (conv_sample)
    );

    assign conv_start = q.pwr && !q.active && grant_vld;
    assign busy       = q.active || (|q.pend);

    // ---- address decode
    logic              hit_trig, hit_stat, hit_misc, hit_data;
    logic [ADDR_W-1:0] rel;
    logic [CH_W-1:0]   data_idx;

    assign hit_trig = (bus_addr == ADDR_W'(OFF_TRIG));
    assign hit_stat = (bus_addr == ADDR_W'(OFF_STAT));
    assign hit_misc = (bus_addr == ADDR_W'(OFF_MISC));
    assign rel      = bus_addr - ADDR_W'(OFF_DATA0);
    assign hit_data = (bus_addr >= ADDR_W'(OFF_DATA0)) && (rel < ADDR_W'(DATA_SPAN))
                      && (rel[1:0] == 2'b00);
    assign data_idx = rel[CH_W+1:2];

    // ---- next state
    always_comb begin
        logic [NUM_CH-1:0] rise, fall;
        d    = q;
        rise = '0;
        fall = '0;
        if (bus_wr && hit_trig) begin
            d.trig = bus_wdata[NUM_CH-1:0];
            rise   = bus_wdata[NUM_CH-1:0] & ~q.trig;
            fall   = q.trig & ~bus_wdata[NUM_CH-1:0];
        end
        if (bus_wr && hit_misc) d.pwr = bus_wdata[PWR_BIT];
        if (conv_done) begin
            d.active      = 1'b0;
            d.data[q.cur] = conv_sample;
            d.rdy[q.cur]  = 1'b1;
        end
        if (conv_start) begin
            d.active = 1'b1;
            d.cur    = conv_ch;
        end
        d.pend = (q.pend & ~(conv_start ? grant : '0)) | rise;
        d.rdy  = d.rdy & ~fall;   // software clear overrides same-edge completion
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // ---- read path
    logic [NUM_CH-1:0][31:0] rd_word;
    for (genvar g = 0; g < NUM_CH; g++) begin : g_rd
        assign rd_word[g] = 32'({q.rdy[g], q.data[g]});
    end

    always_comb begin
        bus_rdata = '0;
        if (hit_trig)      bus_rdata = 32'(q.trig);
        else if (hit_stat) bus_rdata = 32'(busy);
        else if (hit_misc) bus_rdata = 32'(q.pwr) << PWR_BIT;
        else if (hit_data) bus_rdata = rd_word[data_idx];
    end

    // ---- assertions
    AST_DONE_WHILE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done |-> q.active);                                       // R8
    AST_READY_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !conv_done |=> ((q.rdy & ~$past(q.rdy)) == '0));               // R3
    AST_IDLE_WITH_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done && q.pend == '0 && !bus_wr) |=> !busy);             // R5
    AST_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> ((q.pend & ((NUM_CH'(1) << conv_ch) - NUM_CH'(1))) == '0)); // R2
    AST_UNPOWERED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !q.pwr |=> !$rose(q.active));                                  // R6
endmodule

// File: tb/adc_seq_ctrl_tb.sv
module adc_seq_ctrl_tb;
    localparam int LAT = 8;

    logic        clk = 0;
    logic        rst_n = 0;
    logic [7:0]  bus_addr = 0;
    logic        bus_wr = 0;
    logic [31:0] bus_wdata = 0;
    logic [31:0] bus_rdata;
    logic        conv_start;
    logic [3:0]  conv_ch;

    int checks = 0;
    int errors = 0;
    int starts = 0;
    int order_log [0:15];
    int order_n = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    adc_seq_ctrl #(.LATENCY(LAT)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .conv_start(conv_start), .conv_ch(conv_ch)
    );

    always @(negedge clk) begin
        if (rst_n && conv_start) begin
            starts = starts + 1;
            if (order_n < 16) order_log[order_n] = int'(conv_ch);
            order_n = order_n + 1;
        end
    end

    // vectors: {channel, expected result word with ready set}
    localparam logic [31:0] VEC [0:5] = '{
        {16'd0,  16'h105A}, {16'd3,  16'h135D}, {16'd7,  16'h1761},
        {16'd10, 16'h1A64}, {16'd15, 16'h1F69}, {16'd1,  16'h115B}
    };

    function automatic logic [31:0] smp(input int ch);
        return 32'((ch * 257 + 'h5A) % 4096);
    endfunction

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] v);
        @(negedge clk);
        bus_addr = a; bus_wdata = v; bus_wr = 1;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            rd(8'h10, s);
            if (s[0] == 1'b0) return;
        end
    endtask

    initial begin
        #(20 * 150000);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int s0;
        repeat (5) @(posedge clk);
        @(negedge clk); rst_n = 1;

        // R7 reset state
        rd(8'h04, v); chk("R7 trig reset", v, 0);
        rd(8'h10, v); chk("R7 busy reset", v, 0);
        rd(8'h94, v); chk("R7 power reset", v, 0);
        rd(8'h14, v); chk("R7 data reset", v, 0);
        chk("R7 no start at reset", 32'(conv_start), 0);

        // R6 request held while unpowered
        wr(8'h04, 32'h1);
        repeat (40) @(negedge clk);
        rd(8'h10, v); chk("R6 busy while unpowered", v, 1);
        rd(8'h14, v); chk("R6 no result unpowered", v, 0);
        chk("R6 no start unpowered", 32'(starts), 0);
        wr(8'h94, 32'h4000);
        rd(8'h94, v); chk("R6 power readback", v, 32'h4000);
        wait_idle();
        rd(8'h14, v); chk("R6 pending served", v, 32'h105A);
        wr(8'h04, 32'h0);
        rd(8'h14, v); chk("R4 clear keeps sample", v, 32'h005A);

        // R3 exact latency, R5 busy
        wr(8'h04, 32'h2);
        repeat (LAT) @(posedge clk);
        @(negedge clk);
        rd(8'h18, v); chk("R3 not ready early", v, 0);
        rd(8'h10, v); chk("R5 busy in flight", v, 1);
        @(negedge clk);
        rd(8'h18, v); chk("R3 ready on time", v, 32'h1000 | smp(1));
        rd(8'h10, v); chk("R5 idle with last ready", v, 0);

        // R1 rewriting a held bit does not retrigger
        s0 = starts;
        wr(8'h04, 32'h2);
        repeat (30) @(negedge clk);
        chk("R1 no retrigger", 32'(starts - s0), 0);
        rd(8'h10, v); chk("R1 busy stays low", v, 0);
        wr(8'h04, 32'h0);

        // vector table walk (R1, R3)
        for (int k = 0; k < 6; k++) begin
            int ch;
            ch = int'(VEC[k][31:16]);
            wr(8'h04, 32'h0);
            wr(8'h04, 32'h1 << ch);
            wait_idle();
            rd(8'(8'h14 + 4 * ch), v);
            chk("R3 vector result", v, {16'h0, VEC[k][15:0]});
        end
        wr(8'h04, 32'h0);

        // R2 ascending service
        order_n = 0;
        wr(8'h04, (32'h1 << 9) | (32'h1 << 5) | (32'h1 << 2));
        wait_idle();
        chk("R2 start count", 32'(order_n), 3);
        chk("R2 first", 32'(order_log[0]), 2);
        chk("R2 second", 32'(order_log[1]), 5);
        chk("R2 third", 32'(order_log[2]), 9);
        rd(8'h28, v); chk("R2 ch5 result", v, 32'h1000 | smp(5));
        wr(8'h04, 32'h0);

        // R4 clear and completion at the same edge
        wr(8'h04, 32'h10);
        repeat (LAT) @(posedge clk);
        wr(8'h04, 32'h0);
        rd(8'h24, v); chk("R4 collision clear wins", v, smp(4));
        rd(8'h10, v); chk("R5 idle after collision", v, 0);

        // R7 ignored writes, undefined reads
        wr(8'h20, 32'hFFFF_FFFF);
        rd(8'h20, v); chk("R7 data write ignored", v, smp(3));
        rd(8'h00, v); chk("R7 undefined 0x00", v, 0);
        rd(8'h60, v); chk("R7 undefined 0x60", v, 0);
        rd(8'h21, v); chk("R7 misaligned", v, 0);

        // R7 reset clears results
        @(negedge clk); rst_n = 0;
        repeat (2) @(negedge clk); rst_n = 1;
        rd(8'h20, v); chk("R7 data after reset", v, 0);
        rd(8'h94, v); chk("R7 power after reset", v, 0);

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule